// File: doc/BRIEF.md
# SIMT Warp Path Scheduler

This block tracks every divergent control path of a single warp and decides, each cycle, which path is issued next. Each path is one table entry holding a program counter, a per-lane thread mask, an iteration count and a position tag. The tag says whether the path has passed a branch since it last entered a loop body. A branch-outcome interface updates the table. A uniform branch only moves the entry's PC. A divergent branch splits the entry in two and takes one free slot. Paths that reach the same PC on the same iteration are folded back together. Thread exit removes lanes from a path, and a path with no lanes left is freed.

Selection works on two levels. By default the valid path with the lowest PC is issued, which behaves like conventional stack-based reconvergence. A loop detector outside this block marks each path that sits inside a loop already known to diverge. When the lowest-PC path carries that mark, the scheduler looks at all marked paths and issues the one with the most active lanes instead. Paths whose iteration count has run too far ahead of the slowest marked path are left out of that choice. Threads on different iterations can then run in lockstep again.

The surrounding pipeline launches the warp, reports branch, exit and loop back-edge events, and fetches from the selected PC with the selected mask.

Top module: `simt_path_sched`

## Requirements
- R1: After reset the table is empty: `sel_valid` is 0, `sel_mask` is 0 and `overflow` is 0.
- R2: A launch clears the table and `overflow`. It then loads entry 0 with the launch PC and mask and an iteration count of 0. On the next cycle, entry 0 is selected with that PC and mask.
- R3: A branch on a valid path whose active lanes all lie inside the taken mask only sets that entry's PC to the target. A branch whose active lanes all lie outside the taken mask only sets the PC to the fall-through address. Neither case changes the number of valid entries.
- R4: On a divergent branch, the branching entry keeps the lanes that took the branch and gets the target PC. The lowest-numbered free entry receives the remaining lanes, the fall-through PC and the same iteration count. Lane masks of valid entries never overlap.
- R5: When the lowest-PC valid path is not marked as being in a divergent loop, the lowest-PC path is selected. On equal PCs the lower entry index wins.
- R6: Two valid entries with equal PC and equal iteration count are merged in the first cycle after the update that made them equal, provided no event arrives in that cycle. The lower index keeps the OR of both masks and the higher index is freed.
- R7: When the lowest-PC valid path is marked, the selection is made among the marked valid paths and picks the one with the most active lanes. On equal lane counts the lower PC wins, then the lower index.
- R8: Each back-edge event increments the iteration count of its path. In the majority choice of R7, a marked path is excluded when its count exceeds the smallest count among marked valid paths by more than MAX_SHIFT (default 2).
- R9: An exit event removes the given lanes from a path. A path left with no lanes is freed. When no valid path remains, `sel_valid` is 0, and a selected path never has an empty mask.
- R10: A divergent branch that finds no free entry leaves the table unchanged and sets `overflow`. The flag stays set until reset or the next launch.
- R11: `sel_post` is 1 for a path that has taken a branch update since its last launch or back-edge, and 0 after either of those two events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_valid | input | 1 | Start a new warp; highest-priority event |
| launch_pc | input | 16 | Starting PC of the warp |
| launch_mask | input | 8 | Lanes active at launch |
| br_valid | input | 1 | Branch outcome event |
| br_path | input | 3 | Entry that executed the branch |
| br_taken_mask | input | 8 | Lanes that took the branch |
| br_target_pc | input | 16 | PC of the taken side |
| br_fall_pc | input | 16 | PC of the not-taken side |
| exit_valid | input | 1 | Thread exit event |
| exit_path | input | 3 | Entry whose lanes exit |
| exit_mask | input | 8 | Lanes that exit |
| backedge_valid | input | 1 | Back-edge taken event |
| backedge_path | input | 3 | Entry whose iteration count is bumped |
| path_in_div_loop | input | 8 | Per entry: path lies inside a loop that has diverged |
| sel_valid | output | 1 | A path is selected |
| sel_path | output | 3 | Index of the selected entry |
| sel_pc | output | 16 | PC of the selected path (0 when none) |
| sel_mask | output | 8 | Execution mask of the selected path (0 when none) |
| sel_post | output | 1 | Position tag of the selected path |
| overflow | output | 1 | Sticky flag: a split found no free entry |

Events are taken one per cycle in the order launch, branch, exit, back-edge; a merge runs only in a cycle with no event.

## Verification
On every cycle the assertions check several properties: that the lanes of valid paths stay disjoint, that a selected path never has an empty mask, that pure lowest-PC selection holds whenever no valid path is marked, that a uniform branch never changes the number of valid entries, that overflow stays set, and that a launch produces its entry on the next cycle. The bench scenarios cover the policy outcomes that depend on history. These are the one-cycle delay of a merge, the majority choice and its tie-break on PC, the exclusion of a path that is too many iterations ahead and its return after the slower path catches up, the freeing of an emptied path, and an overflow on a table too small to hold all splits.

// File: rtl/simt_path_pkg.sv
// Shared types for the warp path scheduler.
// Assumes nothing beyond IEEE 1800-2017 packages.
package simt_path_pkg;

    // Position of a path relative to the first branch of its loop body.
    typedef enum logic {
        POS_PRE  = 1'b0,
        POS_POST = 1'b1
    } loop_pos_e;

    // Operation applied to the path table in a given cycle.
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_LAUNCH = 3'd1,
        OP_BRANCH = 3'd2,
        OP_EXIT   = 3'd3,
        OP_BACK   = 3'd4,
        OP_MERGE  = 3'd5
    } tbl_op_e;

endpackage

// File: rtl/path_table.sv
// Path table storage: holds PC, lane mask, iteration count and position
// tag per entry, and applies one event per cycle (launch, branch, exit,
// back-edge) or, in an idle cycle, one merge of equal paths.
// Assumes ENTRIES is a power of two so every index value names an entry.
module path_table
    import simt_path_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int ENTRIES = 8,
    parameter int PC_W    = 16,
    parameter int ITER_W  = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            launch_valid,
    input  logic [PC_W-1:0]                 launch_pc,
    input  logic [LANES-1:0]                launch_mask,
    input  logic                            br_valid,
    input  logic [IDX_W-1:0]                br_path,
    input  logic [LANES-1:0]                br_taken_mask,
    input  logic [PC_W-1:0]                 br_target_pc,
    input  logic [PC_W-1:0]                 br_fall_pc,
    input  logic                            exit_valid,
    input  logic [IDX_W-1:0]                exit_path,
    input  logic [LANES-1:0]                exit_mask,
    input  logic                            backedge_valid,
    input  logic [IDX_W-1:0]                backedge_path,
    output logic [ENTRIES-1:0]              ent_valid,
    output logic [ENTRIES-1:0][PC_W-1:0]    ent_pc,
    output logic [ENTRIES-1:0][LANES-1:0]   ent_mask,
    output logic [ENTRIES-1:0][ITER_W-1:0]  ent_iter,
    output logic [ENTRIES-1:0]              ent_post,
    output logic                            overflow
);

    tbl_op_e          op;
    logic             free_ok;
    logic [IDX_W-1:0] free_idx;
    logic             mrg_found;
    logic [IDX_W-1:0] mrg_keep;
    logic [IDX_W-1:0] mrg_drop;
    logic [LANES-1:0] br_tk;
    logic [LANES-1:0] br_nt;
    logic [LANES-1:0] exit_left;

    // Find the lowest-numbered free entry for a split.
    always_comb begin
        free_ok  = 1'b0;
        free_idx = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (!ent_valid[k]) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(k);
            end
        end
    end

    // Find the lowest pair of valid entries with equal PC and iteration.
    always_comb begin
        mrg_found = 1'b0;
        mrg_keep  = '0;
        mrg_drop  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            for (int j = i + 1; j < ENTRIES; j++) begin
                if (!mrg_found && ent_valid[i] && ent_valid[j] &&
                    ent_pc[i] == ent_pc[j] && ent_iter[i] == ent_iter[j]) begin
                    mrg_found = 1'b1;
                    mrg_keep  = IDX_W'(i);
                    mrg_drop  = IDX_W'(j);
                end
            end
        end
    end

    // Split the branching path's lanes and compute lanes left after exit.
    always_comb begin
        br_tk     = br_taken_mask & ent_mask[br_path];
        br_nt     = ent_mask[br_path] & ~br_taken_mask;
        exit_left = ent_mask[exit_path] & ~exit_mask;
    end

    // Pick the single table operation for this cycle by priority.
    always_comb begin
        if (launch_valid)                              op = OP_LAUNCH;
        else if (br_valid && ent_valid[br_path])       op = OP_BRANCH;
        else if (exit_valid && ent_valid[exit_path])   op = OP_EXIT;
        else if (backedge_valid && ent_valid[backedge_path]) op = OP_BACK;
        else if (mrg_found)                            op = OP_MERGE;
        else                                           op = OP_NONE;
    end

    // Apply the chosen operation to the table registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_pc    <= '0;
            ent_mask  <= '0;
            ent_iter  <= '0;
            ent_post  <= '0;
            overflow  <= 1'b0;
        end else begin
            case (op)
                OP_LAUNCH: begin
                    ent_valid    <= '0;
                    ent_mask     <= '0;
                    ent_iter     <= '0;
                    ent_post     <= '0;
                    ent_valid[0] <= |launch_mask;
                    ent_pc[0]    <= launch_pc;
                    ent_mask[0]  <= launch_mask;
                    overflow     <= 1'b0;
                end
                OP_BRANCH: begin
                    if (br_tk != '0 && br_nt != '0) begin
                        if (free_ok) begin
                            ent_mask[br_path]   <= br_tk;
                            ent_pc[br_path]     <= br_target_pc;
                            ent_post[br_path]   <= POS_POST;
                            ent_valid[free_idx] <= 1'b1;
                            ent_mask[free_idx]  <= br_nt;
                            ent_pc[free_idx]    <= br_fall_pc;
                            ent_iter[free_idx]  <= ent_iter[br_path];
                            ent_post[free_idx]  <= POS_POST;
                        end else begin
                            overflow <= 1'b1;
                        end
                    end else begin
                        ent_pc[br_path]   <= (br_tk != '0) ? br_target_pc : br_fall_pc;
                        ent_post[br_path] <= POS_POST;
                    end
                end
                OP_EXIT: begin
                    ent_mask[exit_path] <= exit_left;
                    if (exit_left == '0) begin
                        ent_valid[exit_path] <= 1'b0;
                    end
                end
                OP_BACK: begin
                    if (ent_iter[backedge_path] != '1) begin
                        ent_iter[backedge_path] <= ent_iter[backedge_path] + 1'b1;
                    end
                    ent_post[backedge_path] <= POS_PRE;
                end
                OP_MERGE: begin
                    ent_mask[mrg_keep]  <= ent_mask[mrg_keep] | ent_mask[mrg_drop];
                    ent_mask[mrg_drop]  <= '0;
                    ent_valid[mrg_drop] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/path_select.sv
// Two-level path selection: lowest PC by default; when that path is marked
// as inside a divergent loop, the most populated marked path whose
// iteration count is within MAX_SHIFT of the slowest marked path.
// Assumes all marked paths belong to the same loop. Purely combinational.
module path_select #(
    parameter int LANES     = 8,
    parameter int ENTRIES   = 8,
    parameter int PC_W      = 16,
    parameter int ITER_W    = 4,
    parameter int MAX_SHIFT = 2,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]              ent_valid,
    input  logic [ENTRIES-1:0][PC_W-1:0]    ent_pc,
    input  logic [ENTRIES-1:0][LANES-1:0]   ent_mask,
    input  logic [ENTRIES-1:0][ITER_W-1:0]  ent_iter,
    input  logic [ENTRIES-1:0]              loop_flag,
    output logic                            sel_valid,
    output logic [IDX_W-1:0]                sel_idx
);

    logic              min_found;
    logic [IDX_W-1:0]  min_idx;
    logic [PC_W-1:0]   min_pc;
    logic              iter_found;
    logic [ITER_W-1:0] iter_floor;
    logic [ENTRIES-1:0] eligible;
    logic              maj_found;
    logic [IDX_W-1:0]  maj_idx;
    logic [PC_W-1:0]   maj_pc;
    int                maj_pop;

    // First level: lowest PC among valid paths, lower index on ties.
    always_comb begin
        min_found = 1'b0;
        min_idx   = '0;
        min_pc    = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (ent_valid[k] && (!min_found || ent_pc[k] < min_pc)) begin
                min_found = 1'b1;
                min_idx   = IDX_W'(k);
                min_pc    = ent_pc[k];
            end
        end
    end

    // Iteration floor of the marked paths and the shift window it allows.
    always_comb begin
        iter_found = 1'b0;
        iter_floor = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (ent_valid[k] && loop_flag[k] &&
                (!iter_found || ent_iter[k] < iter_floor)) begin
                iter_found = 1'b1;
                iter_floor = ent_iter[k];
            end
        end
        for (int k = 0; k < ENTRIES; k++) begin
            eligible[k] = ent_valid[k] && loop_flag[k] &&
                          (int'(ent_iter[k]) <= int'(iter_floor) + MAX_SHIFT);
        end
    end

    // Second level: most lanes among eligible paths, lower PC on ties.
    always_comb begin
        int pop;
        maj_found = 1'b0;
        maj_idx   = '0;
        maj_pc    = '0;
        maj_pop   = 0;
        for (int k = 0; k < ENTRIES; k++) begin
            pop = int'($countones(ent_mask[k]));
            if (eligible[k] && (!maj_found || pop > maj_pop ||
                                (pop == maj_pop && ent_pc[k] < maj_pc))) begin
                maj_found = 1'b1;
                maj_idx   = IDX_W'(k);
                maj_pc    = ent_pc[k];
                maj_pop   = pop;
            end
        end
    end

    // Choose between the two levels.
    always_comb begin
        sel_valid = min_found;
        sel_idx   = (min_found && loop_flag[min_idx] && maj_found) ? maj_idx : min_idx;
    end

endmodule

// File: rtl/simt_path_sched.sv
// Top of the warp path scheduler: path table plus selection policy, with
// the selected entry's fields driven to the outputs (zero when none).
// Assumes the caller presents at most the events it intends per cycle;
// lower-priority events in the same cycle are dropped.
module simt_path_sched #(
    parameter int LANES     = 8,
    parameter int ENTRIES   = 8,
    parameter int PC_W      = 16,
    parameter int ITER_W    = 4,
    parameter int MAX_SHIFT = 2,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch_valid,
    input  logic [PC_W-1:0]    launch_pc,
    input  logic [LANES-1:0]   launch_mask,
    input  logic               br_valid,
    input  logic [IDX_W-1:0]   br_path,
    input  logic [LANES-1:0]   br_taken_mask,
    input  logic [PC_W-1:0]    br_target_pc,
    input  logic [PC_W-1:0]    br_fall_pc,
    input  logic               exit_valid,
    input  logic [IDX_W-1:0]   exit_path,
    input  logic [LANES-1:0]   exit_mask,
    input  logic               backedge_valid,
    input  logic [IDX_W-1:0]   backedge_path,
    input  logic [ENTRIES-1:0] path_in_div_loop,
    output logic               sel_valid,
    output logic [IDX_W-1:0]   sel_path,
    output logic [PC_W-1:0]    sel_pc,
    output logic [LANES-1:0]   sel_mask,
    output logic               sel_post,
    output logic               overflow
);

    logic [ENTRIES-1:0]              ent_valid;
    logic [ENTRIES-1:0][PC_W-1:0]    ent_pc;
    logic [ENTRIES-1:0][LANES-1:0]   ent_mask;
    logic [ENTRIES-1:0][ITER_W-1:0]  ent_iter;
    logic [ENTRIES-1:0]              ent_post;
    logic                            pick_valid;
    logic [IDX_W-1:0]                pick_idx;

    path_table #(
        .LANES(LANES), .ENTRIES(ENTRIES), .PC_W(PC_W), .ITER_W(ITER_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_pc(launch_pc), .launch_mask(launch_mask),
        .br_valid(br_valid), .br_path(br_path), .br_taken_mask(br_taken_mask),
        .br_target_pc(br_target_pc), .br_fall_pc(br_fall_pc),
        .exit_valid(exit_valid), .exit_path(exit_path), .exit_mask(exit_mask),
        .backedge_valid(backedge_valid), .backedge_path(backedge_path),
        .ent_valid(ent_valid), .ent_pc(ent_pc), .ent_mask(ent_mask),
        .ent_iter(ent_iter), .ent_post(ent_post), .overflow(overflow)
    );

    path_select #(
        .LANES(LANES), .ENTRIES(ENTRIES), .PC_W(PC_W), .ITER_W(ITER_W),
        .MAX_SHIFT(MAX_SHIFT)
    ) u_select (
        .ent_valid(ent_valid), .ent_pc(ent_pc), .ent_mask(ent_mask),
        .ent_iter(ent_iter), .loop_flag(path_in_div_loop),
        .sel_valid(pick_valid), .sel_idx(pick_idx)
    );

    // Drive the selected entry's fields, zero when the table is empty.
    always_comb begin
        sel_valid = pick_valid;
        sel_path  = pick_idx;
        sel_pc    = pick_valid ? ent_pc[pick_idx]   : '0;
        sel_mask  = pick_valid ? ent_mask[pick_idx] : '0;
        sel_post  = pick_valid ? ent_post[pick_idx] : 1'b0;
    end

endmodule

// File: rtl/simt_path_sched_chk.sv
// Property checker for the warp path scheduler, bound to every instance.
// Assumes it sees the table state through the top's internal signals.
module simt_path_sched_chk #(
    parameter int LANES   = 8,
    parameter int ENTRIES = 8,
    parameter int PC_W    = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            launch_valid,
    input logic [PC_W-1:0]                 launch_pc,
    input logic [LANES-1:0]                launch_mask,
    input logic                            br_valid,
    input logic [IDX_W-1:0]                br_path,
    input logic [LANES-1:0]                br_taken_mask,
    input logic [ENTRIES-1:0]              path_in_div_loop,
    input logic [ENTRIES-1:0]              ent_valid,
    input logic [ENTRIES-1:0][PC_W-1:0]    ent_pc,
    input logic [ENTRIES-1:0][LANES-1:0]   ent_mask,
    input logic                            sel_valid,
    input logic [PC_W-1:0]                 sel_pc,
    input logic [LANES-1:0]                sel_mask,
    input logic                            overflow
);

    int              lane_sum;
    logic [LANES-1:0] lane_union;
    logic [PC_W-1:0] low_pc;
    logic            uniform_br;

    // Reference lane totals and lowest valid PC.
    always_comb begin
        lane_sum   = 0;
        lane_union = '0;
        low_pc     = '1;
        for (int k = 0; k < ENTRIES; k++) begin
            if (ent_valid[k]) begin
                lane_sum   = lane_sum + int'($countones(ent_mask[k]));
                lane_union = lane_union | ent_mask[k];
                if (ent_pc[k] < low_pc) low_pc = ent_pc[k];
            end
        end
        uniform_br = br_valid && !launch_valid && ent_valid[br_path] &&
                     (((br_taken_mask & ent_mask[br_path]) == '0) ||
                      ((ent_mask[br_path] & ~br_taken_mask) == '0));
    end

    assert_lanes_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lane_sum == int'($countones(lane_union)));

    assert_sel_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> sel_mask != '0);

    assert_min_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && (ent_valid & path_in_div_loop) == '0) |-> sel_pc == low_pc);

    assert_uniform_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        uniform_br |=> $countones(ent_valid) == $past($countones(ent_valid)));

    assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !launch_valid) |=> overflow);

    assert_launch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && launch_mask != '0) |=>
            (sel_valid && sel_pc == $past(launch_pc) &&
             sel_mask == $past(launch_mask) && !overflow));

endmodule

bind simt_path_sched simt_path_sched_chk #(
    .LANES(LANES), .ENTRIES(ENTRIES), .PC_W(PC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_pc(launch_pc), .launch_mask(launch_mask),
    .br_valid(br_valid), .br_path(br_path), .br_taken_mask(br_taken_mask),
    .path_in_div_loop(path_in_div_loop),
    .ent_valid(ent_valid), .ent_pc(ent_pc), .ent_mask(ent_mask),
    .sel_valid(sel_valid), .sel_pc(sel_pc), .sel_mask(sel_mask),
    .overflow(overflow)
);

// File: tb/test_simt_path_sched.sv
`timescale 1ns/1ps
module test_simt_path_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch_valid = 1'b0;
    logic [15:0] launch_pc = '0;
    logic [7:0]  launch_mask = '0;
    logic        br_valid = 1'b0;
    logic [2:0]  br_path = '0;
    logic [7:0]  br_taken_mask = '0;
    logic [15:0] br_target_pc = '0;
    logic [15:0] br_fall_pc = '0;
    logic        exit_valid = 1'b0;
    logic [2:0]  exit_path = '0;
    logic [7:0]  exit_mask = '0;
    logic        backedge_valid = 1'b0;
    logic [2:0]  backedge_path = '0;
    logic [7:0]  path_in_div_loop = '0;
    logic        sel_valid;
    logic [2:0]  sel_path;
    logic [15:0] sel_pc;
    logic [7:0]  sel_mask;
    logic        sel_post;
    logic        overflow;

    // Small-table instance used only for the overflow scenario.
    logic        s_launch_valid = 1'b0;
    logic        s_br_valid = 1'b0;
    logic [1:0]  s_br_path = '0;
    logic        s_sel_valid;
    logic [1:0]  s_sel_path;
    logic [15:0] s_sel_pc;
    logic [7:0]  s_sel_mask;
    logic        s_sel_post;
    logic        s_overflow;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    simt_path_sched i_simt_path_sched (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_pc(launch_pc), .launch_mask(launch_mask),
        .br_valid(br_valid), .br_path(br_path), .br_taken_mask(br_taken_mask),
        .br_target_pc(br_target_pc), .br_fall_pc(br_fall_pc),
        .exit_valid(exit_valid), .exit_path(exit_path), .exit_mask(exit_mask),
        .backedge_valid(backedge_valid), .backedge_path(backedge_path),
        .path_in_div_loop(path_in_div_loop),
        .sel_valid(sel_valid), .sel_path(sel_path), .sel_pc(sel_pc),
        .sel_mask(sel_mask), .sel_post(sel_post), .overflow(overflow)
    );

    simt_path_sched #(.ENTRIES(4)) i_simt_path_sched_small (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(s_launch_valid), .launch_pc(launch_pc), .launch_mask(launch_mask),
        .br_valid(s_br_valid), .br_path(s_br_path), .br_taken_mask(br_taken_mask),
        .br_target_pc(br_target_pc), .br_fall_pc(br_fall_pc),
        .exit_valid(1'b0), .exit_path(2'd0), .exit_mask(8'h00),
        .backedge_valid(1'b0), .backedge_path(2'd0),
        .path_in_div_loop(4'h0),
        .sel_valid(s_sel_valid), .sel_path(s_sel_path), .sel_pc(s_sel_pc),
        .sel_mask(s_sel_mask), .sel_post(s_sel_post), .overflow(s_overflow)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic expect_sel(input string req, input logic v, input logic [2:0] idx,
                              input logic [15:0] pc, input logic [7:0] mask);
        #1;
        check(req, "sel_valid", 32'(sel_valid), 32'(v));
        check(req, "sel_path",  32'(sel_path),  32'(idx));
        check(req, "sel_pc",    32'(sel_pc),    32'(pc));
        check(req, "sel_mask",  32'(sel_mask),  32'(mask));
    endtask

    task automatic do_launch(input logic [15:0] pc, input logic [7:0] mask);
        @(negedge clk);
        launch_valid = 1'b1; s_launch_valid = 1'b1;
        launch_pc = pc; launch_mask = mask;
        @(negedge clk);
        launch_valid = 1'b0; s_launch_valid = 1'b0;
    endtask

    task automatic do_branch(input logic [2:0] p, input logic [7:0] tk,
                             input logic [15:0] tgt, input logic [15:0] fall);
        @(negedge clk);
        br_valid = 1'b1; br_path = p; br_taken_mask = tk;
        br_target_pc = tgt; br_fall_pc = fall;
        @(negedge clk);
        br_valid = 1'b0;
    endtask

    task automatic do_small_branch(input logic [1:0] p, input logic [7:0] tk,
                                   input logic [15:0] tgt, input logic [15:0] fall);
        @(negedge clk);
        s_br_valid = 1'b1; s_br_path = p; br_taken_mask = tk;
        br_target_pc = tgt; br_fall_pc = fall;
        @(negedge clk);
        s_br_valid = 1'b0;
    endtask

    task automatic do_exit(input logic [2:0] p, input logic [7:0] m);
        @(negedge clk);
        exit_valid = 1'b1; exit_path = p; exit_mask = m;
        @(negedge clk);
        exit_valid = 1'b0;
    endtask

    task automatic do_backedge(input logic [2:0] p);
        @(negedge clk);
        backedge_valid = 1'b1; backedge_path = p;
        @(negedge clk);
        backedge_valid = 1'b0;
    endtask

    // R1: empty after reset.
    task automatic t_reset();
        #1;
        check("R1", "sel_valid", 32'(sel_valid), 32'd0);
        check("R1", "sel_mask",  32'(sel_mask),  32'd0);
        check("R1", "overflow",  32'(overflow),  32'd0);
    endtask

    // R2, R11 on launch; R3 uniform branches.
    task automatic t_launch_uniform();
        do_launch(16'h0010, 8'hFF);
        expect_sel("R2", 1'b1, 3'd0, 16'h0010, 8'hFF);
        check("R11", "sel_post after launch", 32'(sel_post), 32'd0);
        do_branch(3'd0, 8'hFF, 16'h0040, 16'h0014);
        expect_sel("R3", 1'b1, 3'd0, 16'h0040, 8'hFF);
        check("R11", "sel_post after branch", 32'(sel_post), 32'd1);
        do_branch(3'd0, 8'h00, 16'h0090, 16'h0044);
        expect_sel("R3", 1'b1, 3'd0, 16'h0044, 8'hFF);
    endtask

    // R4 split, R5 min PC and tie, R6 merge timing.
    task automatic t_split_merge();
        do_branch(3'd0, 8'h0F, 16'h0080, 16'h0048);
        expect_sel("R4", 1'b1, 3'd1, 16'h0048, 8'hF0);
        do_branch(3'd1, 8'hFF, 16'h0080, 16'h004C);
        expect_sel("R5", 1'b1, 3'd0, 16'h0080, 8'h0F);
        @(negedge clk);
        expect_sel("R6", 1'b1, 3'd0, 16'h0080, 8'hFF);
    endtask

    // R7 majority and R8 iteration window, R11 tag after back-edge.
    task automatic t_majority_bias();
        path_in_div_loop = 8'h00;
        do_launch(16'h0010, 8'hFF);
        do_branch(3'd0, 8'h07, 16'h0020, 16'h0030);
        expect_sel("R5", 1'b1, 3'd0, 16'h0020, 8'h07);
        path_in_div_loop = 8'h03;
        expect_sel("R7", 1'b1, 3'd1, 16'h0030, 8'hF8);
        do_backedge(3'd1);
        do_backedge(3'd1);
        expect_sel("R8", 1'b1, 3'd1, 16'h0030, 8'hF8);
        check("R11", "sel_post after back-edge", 32'(sel_post), 32'd0);
        do_backedge(3'd1);
        expect_sel("R8", 1'b1, 3'd0, 16'h0020, 8'h07);
        check("R11", "sel_post of split path", 32'(sel_post), 32'd1);
        do_backedge(3'd0);
        expect_sel("R8", 1'b1, 3'd1, 16'h0030, 8'hF8);
        path_in_div_loop = 8'h00;
    endtask

    // R7 tie on lane count resolved by lower PC; then R9 exits.
    task automatic t_tie_exit();
        do_launch(16'h0010, 8'hFF);
        do_branch(3'd0, 8'h03, 16'h0020, 16'h0030);
        do_branch(3'd1, 8'h1C, 16'h0028, 16'h0030);
        path_in_div_loop = 8'h07;
        expect_sel("R7", 1'b1, 3'd1, 16'h0028, 8'h1C);
        path_in_div_loop = 8'h00;
        expect_sel("R5", 1'b1, 3'd0, 16'h0020, 8'h03);
        do_exit(3'd0, 8'h01);
        expect_sel("R9", 1'b1, 3'd0, 16'h0020, 8'h02);
        do_exit(3'd0, 8'h02);
        expect_sel("R9", 1'b1, 3'd1, 16'h0028, 8'h1C);
        do_exit(3'd1, 8'hFF);
        do_exit(3'd2, 8'hFF);
        expect_sel("R9", 1'b0, 3'd0, 16'h0000, 8'h00);
    endtask

    // R10 overflow on a four-entry table, cleared by launch.
    task automatic t_overflow();
        do_launch(16'h0010, 8'hFF);
        do_small_branch(2'd0, 8'h01, 16'h0101, 16'h0200);
        do_small_branch(2'd1, 8'h02, 16'h0102, 16'h0201);
        do_small_branch(2'd2, 8'h04, 16'h0103, 16'h0202);
        #1;
        check("R10", "overflow before full split", 32'(s_overflow), 32'd0);
        do_small_branch(2'd3, 8'h08, 16'h0104, 16'h0203);
        #1;
        check("R10", "overflow set", 32'(s_overflow), 32'd1);
        check("R10", "selection unchanged pc", 32'(s_sel_pc), 32'h0101);
        check("R10", "selection unchanged mask", 32'(s_sel_mask), 32'h01);
        @(negedge clk);
        #1;
        check("R10", "overflow held", 32'(s_overflow), 32'd1);
        do_launch(16'h0010, 8'hFF);
        #1;
        check("R10", "overflow cleared by launch", 32'(s_overflow), 32'd0);
        check("R2", "small launch pc", 32'(s_sel_pc), 32'h0010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_launch_uniform();
        t_split_merge();
        t_majority_bias();
        t_tie_exit();
        t_overflow();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule